// File: doc/BRIEF.md
# Indexed clock configuration register bank

This block puts four clock-output configuration slots behind one 32-bit bus register. Each slot holds an enable bit, a 5-bit source-select code and a 3-bit divisor code. Software reaches the slots indirectly. It writes the register with a slot index and a command bit. Command 1 stores the carried fields into the indexed slot. Command 0 asks for the indexed slot's contents to be copied into the register, so that the next read at the same address returns them.

All four slot configurations leave the block on flat output vectors that feed the downstream clock generators. Writes that name a nonexistent slot, or that carry a source code with no clock behind it, do not reach any slot. The bus side is a plain synchronous port: address, write strobe, write data and combinational read data.

Top module: `clk_cfg_bank`

## Requirements
- R1: An active-low asynchronous reset clears all four slots to disabled, source 0 and divisor 0. It also clears the register, so a read at offset 0x030 returns 0.
- R2: A write at offset 0x030 with bit 7 = 1 and an index of 1..4 in bits 3:0 stores bit 28 (enable), bits 20:16 (source) and bits 10:8 (divisor) into slot index-1. The slot outputs show the new values from the next clock edge.
- R3: A write command whose index is 0 or 5..15 leaves every slot unchanged.
- R4: A write command whose source code is 4, or any code from 11 to 31, leaves the indexed slot unchanged.
- R5: A write at offset 0x030 with bit 7 = 0 and a valid index loads the register with that slot's enable, source and divisor in the same bit positions, bit 7 = 0 and the index in bits 3:0. The next read returns this word.
- R6: Bits 31:29, 27:21, 15:11 and 6:4 always read as 0, whatever was written into them. A read at any address other than 0x030 returns 0.
- R7: Writes to any address other than 0x030 change neither the slots nor the register.
- R8: A read command with an index outside 1..4 loads the register with zero fields, bit 7 = 0 and the index in bits 3:0.
- R9: After a write command, the register shows the written enable, source, divisor, index and bit 7 = 1, even when the slot rejected the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational on addr_i) |
| slot_en_o | output | 4 | Enable per slot, bit i is slot i |
| slot_src_o | output | 20 | Source code per slot, 5 bits each, slot i at [5i+4:5i] |
| slot_div_o | output | 12 | Divisor code per slot, 3 bits each, slot i at [3i+2:3i] |

## Verification
A single write-command edge does two things at once: it updates a slot and it overwrites the visible register with the echoed fields. When a slot rejects the update, the two outcomes split apart. The bench provokes this with writes that carry a reserved source or an out-of-range index. It then reads the register straight away to see the echo, and afterwards issues a read command to show that the slot kept its old contents. The slot output vectors are compared at the end of the sequence as a second view of the same storage.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int DATA_W   = 32;
  localparam int EN_BIT   = 28;
  localparam int SRC_LSB  = 16;
  localparam int SRC_W    = 5;
  localparam int DIV_LSB  = 8;
  localparam int DIV_W    = 3;
  localparam int CMD_BIT  = 7;
  localparam int IDX_LSB  = 0;
  localparam int IDX_W    = 4;
  localparam int SRC_RSVD = 4;
  localparam int SRC_MAX  = 10;

  typedef struct packed {
    logic             en;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } slot_cfg_t;

  function automatic logic src_valid(logic [SRC_W-1:0] s);
    return (s <= SRC_W'(SRC_MAX)) && (s != SRC_W'(SRC_RSVD));
  endfunction

  function automatic logic [DATA_W-1:0] pack_word(slot_cfg_t c, logic cmd,
                                                  logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT]               = c.en;
    w[SRC_LSB +: SRC_W]     = c.src;
    w[DIV_LSB +: DIV_W]     = c.div;
    w[CMD_BIT]              = cmd;
    w[IDX_LSB +: IDX_W]     = idx;
    return w;
  endfunction
endpackage

// File: rtl/clk_cfg_decode.sv
module clk_cfg_decode
  import clk_cfg_pkg::*;
#(
  parameter int              N_SLOTS    = 4,
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h030
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              wr_cmd_o,
  output logic              rd_cmd_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              idx_ok_o,
  output logic [N_SLOTS-1:0] sel_o,
  output logic              src_ok_o,
  output slot_cfg_t         req_o
);
  logic cmd;
  logic unused_wbits;

  assign hit_o    = (addr_i == REG_OFFSET);
  assign cmd      = wdata_i[CMD_BIT];
  assign wr_cmd_o = hit_o && we_i && cmd;
  assign rd_cmd_o = hit_o && we_i && !cmd;
  assign idx_o    = wdata_i[IDX_LSB +: IDX_W];
  assign idx_ok_o = (idx_o != '0) && (idx_o <= IDX_W'(N_SLOTS));

  assign req_o.en  = wdata_i[EN_BIT];
  assign req_o.src = wdata_i[SRC_LSB +: SRC_W];
  assign req_o.div = wdata_i[DIV_LSB +: DIV_W];
  assign src_ok_o  = src_valid(req_o.src);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_sel
    assign sel_o[i] = (idx_o == IDX_W'(i + 1));
  end

  assign unused_wbits = ^{wdata_i[31:29], wdata_i[27:21], wdata_i[15:11], wdata_i[6:4]};
endmodule

// File: rtl/clk_cfg_slot.sv
module clk_cfg_slot
  import clk_cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  slot_cfg_t din_i,
  output slot_cfg_t cfg_o
);
  slot_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= din_i;
  end

  assign cfg_o = cfg_q;

  // slot holds whenever the decoder does not strobe it
  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_o));
  assert_slot_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cfg_o == $past(din_i));
endmodule

// File: rtl/clk_cfg_view.sv
module clk_cfg_view
  import clk_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              rd_cmd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              idx_ok_i,
  input  slot_cfg_t         req_i,
  input  slot_cfg_t         sel_cfg_i,
  output logic [DATA_W-1:0] view_o
);
  logic [DATA_W-1:0] view_q;
  slot_cfg_t         rd_cfg;

  assign rd_cfg = idx_ok_i ? sel_cfg_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       view_q <= '0;
    else if (wr_cmd_i) view_q <= pack_word(req_i, 1'b1, idx_i);
    else if (rd_cmd_i) view_q <= pack_word(rd_cfg, 1'b0, idx_i);
  end

  assign view_o = view_q;

  assert_read_fetch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_i && idx_ok_i |=>
      view_o[EN_BIT] == $past(sel_cfg_i.en) &&
      view_o[SRC_LSB +: SRC_W] == $past(sel_cfg_i.src) &&
      view_o[DIV_LSB +: DIV_W] == $past(sel_cfg_i.div) && !view_o[CMD_BIT]);
  assert_read_bad_idx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_i && !idx_ok_i |=>
      !view_o[EN_BIT] && view_o[SRC_LSB +: SRC_W] == '0 && view_o[DIV_LSB +: DIV_W] == '0);
  assert_view_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cmd_i && !rd_cmd_i |=> $stable(view_o));
endmodule

// File: rtl/clk_cfg_bank.sv
module clk_cfg_bank
  import clk_cfg_pkg::*;
#(
  parameter int                N_SLOTS    = 4,
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h030,
  localparam int               SRC_BUS_W  = N_SLOTS * SRC_W,
  localparam int               DIV_BUS_W  = N_SLOTS * DIV_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [N_SLOTS-1:0]   slot_en_o,
  output logic [SRC_BUS_W-1:0] slot_src_o,
  output logic [DIV_BUS_W-1:0] slot_div_o
);
  logic               hit, wr_cmd, rd_cmd, idx_ok, src_ok;
  logic [IDX_W-1:0]   idx;
  logic [N_SLOTS-1:0] sel;
  slot_cfg_t          req, sel_cfg;
  slot_cfg_t          slot_cfg [N_SLOTS];
  logic [DATA_W-1:0]  view;

  clk_cfg_decode #(
    .N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
  ) u_decode (
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .hit_o(hit), .wr_cmd_o(wr_cmd), .rd_cmd_o(rd_cmd),
    .idx_o(idx), .idx_ok_o(idx_ok), .sel_o(sel),
    .src_ok_o(src_ok), .req_o(req)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    clk_cfg_slot u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(wr_cmd && sel[i] && src_ok),
      .din_i(req), .cfg_o(slot_cfg[i])
    );
    assign slot_en_o[i]                = slot_cfg[i].en;
    assign slot_src_o[i*SRC_W +: SRC_W] = slot_cfg[i].src;
    assign slot_div_o[i*DIV_W +: DIV_W] = slot_cfg[i].div;
  end

  always_comb begin
    sel_cfg = '0;
    for (int i = 0; i < N_SLOTS; i++)
      if (sel[i]) sel_cfg = slot_cfg[i];
  end

  clk_cfg_view u_view (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_cmd_i(wr_cmd), .rd_cmd_i(rd_cmd),
    .idx_i(idx), .idx_ok_i(idx_ok),
    .req_i(req), .sel_cfg_i(sel_cfg), .view_o(view)
  );

  assign rdata_o = hit ? view : '0;

  // port-level checks
  logic wr_port, bad_idx_port, bad_src_port;
  assign wr_port      = we_i && (addr_i == REG_OFFSET) && wdata_i[CMD_BIT];
  assign bad_idx_port = (wdata_i[IDX_LSB +: IDX_W] == '0) ||
                        (wdata_i[IDX_LSB +: IDX_W] > IDX_W'(N_SLOTS));
  assign bad_src_port = (wdata_i[SRC_LSB +: SRC_W] == SRC_W'(SRC_RSVD)) ||
                        (wdata_i[SRC_LSB +: SRC_W] > SRC_W'(SRC_MAX));

  assert_bad_idx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_port && bad_idx_port |=> $stable({slot_en_o, slot_src_o, slot_div_o}));
  assert_bad_src_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_port && bad_src_port |=> $stable({slot_en_o, slot_src_o, slot_div_o}));
  assert_other_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (addr_i != REG_OFFSET) |=> $stable({slot_en_o, slot_src_o, slot_div_o}));
  assert_echo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_port ##1 (addr_i == REG_OFFSET) |->
      rdata_o[CMD_BIT] && rdata_o[IDX_LSB +: IDX_W] == $past(wdata_i[IDX_LSB +: IDX_W]));
endmodule

// File: tb/clk_cfg_bank_tb.sv
`timescale 1ns/1ps
module clk_cfg_bank_tb;
  localparam logic [11:0] OFF = 12'h030;

  typedef struct packed {
    logic [31:0] wr;
    logic [3:0]  rd_id;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // write word, slot to read back, expected read word, requirement number
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h10050381, 4'd1, 32'h10050301, 4'd2},  // R2
    '{32'h000A0782, 4'd2, 32'h000A0702, 4'd2},
    '{32'h10000083, 4'd3, 32'h10000003, 4'd2},
    '{32'h10090684, 4'd4, 32'h10090604, 4'd2},
    '{32'hFFE5F8F1, 4'd1, 32'h10050001, 4'd6},  // R6 junk in unused bits
    '{32'h10040182, 4'd2, 32'h000A0702, 4'd4},  // R4 source 4
    '{32'h000B0283, 4'd3, 32'h10000003, 4'd4},  // source 11
    '{32'h101F0084, 4'd4, 32'h10090604, 4'd4},  // source 31
    '{32'h00020585, 4'd1, 32'h10050001, 4'd3},  // R3 index 5
    '{32'h00020580, 4'd4, 32'h10090604, 4'd3},  // index 0
    '{32'h0002078F, 4'd2, 32'h000A0702, 4'd3},  // index 15
    '{32'h00030184, 4'd4, 32'h00030104, 4'd2},
    '{32'h10020482, 4'd2, 32'h10020402, 4'd5}   // R5
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = OFF;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  slot_en_o;
  logic [19:0] slot_src_o;
  logic [11:0] slot_div_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  clk_cfg_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .slot_en_o(slot_en_o),
    .slot_src_o(slot_src_o), .slot_div_o(slot_div_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = OFF;
    #1;
  endtask

  task automatic read_at(logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
    addr_i = OFF;
    #1;
  endtask

  initial begin
    logic [31:0] r;
    #3;
    // R1 reset state
    check("R1", rdata_o, 0);
    check("R1", {slot_en_o, slot_src_o, slot_div_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      bus_write(OFF, VECS[i].wr);
      bus_write(OFF, {28'b0, VECS[i].rd_id});
      read_at(OFF, r);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), r, VECS[i].exp);
    end

    // R2 exported slot state after the table
    check("R2", slot_en_o, 4'b0111);
    check("R2", slot_src_o, {5'd3, 5'd0, 5'd2, 5'd5});
    check("R2", slot_div_o, {3'd1, 3'd0, 3'd4, 3'd0});

    // R9 echo after rejected write, then slot kept (R4)
    bus_write(OFF, 32'h10040182);
    read_at(OFF, r);
    check("R9", r, 32'h10040182);
    bus_write(OFF, 32'h00000002);
    read_at(OFF, r);
    check("R4", r, 32'h10020402);

    // R9 / R6 echo masks unused bits
    bus_write(OFF, 32'hFFE5F8F1);
    read_at(OFF, r);
    check("R6", r, 32'h10050081);

    // R8 read command with bad index
    bus_write(OFF, 32'h00000000);
    read_at(OFF, r);
    check("R8", r, 32'h00000000);
    bus_write(OFF, 32'h00000007);
    read_at(OFF, r);
    check("R8", r, 32'h00000007);

    // R6 other address reads zero
    read_at(12'h034, r);
    check("R6", r, 0);

    // R7 write elsewhere has no effect
    bus_write(12'h034, 32'h10000081);
    check("R7", slot_src_o[4:0], 5'd5);
    read_at(OFF, r);
    check("R7", r, 32'h00000007);

    // R1 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", rdata_o, 0);
    check("R1", {slot_en_o, slot_src_o, slot_div_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_write(OFF, 32'h00000001);
    read_at(OFF, r);
    check("R1", r, 32'h00000001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule